// File: doc/BRIEF.md
# Opcode-Aware Reply Timeout Scheduler

This block paces request/reply exchanges that a host runs over a slow byte link. A client asks for an exchange with a start strobe and an opcode. The scheduler grants the request with a launch pulse once the link is free, and the serializer then sends the bytes. When the serializer reports that the last byte has gone out, the scheduler opens a reply window measured in millisecond ticks. The length of that window comes from a small writable table, which lists the few opcodes that need a long time to answer. Any opcode not found in the table gets a short default window.

The first received byte inside the window ends the exchange with an ok pulse. If the window runs out first, the exchange ends with a timeout pulse. After either outcome a fixed guard gap must pass before the next exchange may launch. This gap gives the far end's receiver time to drop back to its idle framing state. A request that arrives while an exchange or gap is in progress is kept in one pending slot, not lost. Retries and the byte serialization itself are handled outside the block.

Top module: `reply_pacer`

## Requirements
- R1: After reset, busy, ok, timeout and launch are all 0, and every table entry is invalid.
- R2: When the block is idle, a req_start strobe is captured. In the next cycle, launch pulses for one cycle with launch_op equal to the captured opcode, and busy is 1 from the cycle after launch until the guard gap ends.
- R3: A req_start that arrives while busy is held in a single pending slot. A later strobe replaces the held opcode. The held request launches in the first idle cycle after the gap.
- R4: A write with tbl_we stores tbl_valid, tbl_opcode and tbl_ms in entry tbl_idx. The entry is used for every tx_done that follows the write.
- R5: The reply window is the tbl_ms of the lowest-indexed valid entry whose opcode matches the launched opcode. With no match, the window is DEFAULT_MS (15) ticks.
- R6: If no rx_byte arrives, timeout pulses in the cycle after the window's Nth ms_tick, counting only ticks sampled after the tx_done cycle.
- R7: The first rx_byte inside the window gives an ok pulse in the next cycle. Later reply bytes have no effect. An rx_byte that arrives together with the expiring tick wins, and the result is ok.
- R8: ok and timeout are single-cycle pulses that never occur together, and exactly one of them occurs per launched request.
- R9: rx_byte outside the reply window and tx_done outside the sending phase are ignored.
- R10: After an ok or timeout pulse, no launch occurs until GAP_MS (32) ms_ticks have been sampled. A launch that is pending comes in the cycle after the 32nd tick.
- R11: A table window value of 0 behaves like 1 tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_start | input | 1 | Request strobe |
| req_opcode | input | OP_W | Opcode of the request |
| tx_done | input | 1 | Last request byte has left |
| rx_byte | input | 1 | A reply byte was received |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | $clog2(ENTRIES) | Entry to write |
| tbl_valid | input | 1 | Entry valid bit written |
| tbl_opcode | input | OP_W | Opcode matched by the entry |
| tbl_ms | input | MS_W | Window length of the entry, in ticks |
| busy | output | 1 | Exchange or guard gap in progress |
| ok | output | 1 | Reply arrived (pulse) |
| timeout | output | 1 | Window expired (pulse) |
| launch | output | 1 | Start sending the granted request (pulse) |
| launch_op | output | OP_W | Opcode of the granted request |

## Verification
A wrong window count shows up as a timeout pulse that arrives one or more ticks early or late compared with the count of ticks since tx_done. A reference model that follows the same tick stream exposes this on the exact clock of the pulse. A corrupted phase or pending slot shows up within one cycle as busy or launch disagreeing with the model, or as a launch that lands inside the 32-tick gap. Table faults appear only on the next exchange that uses the affected opcode, when the measured window length comes out wrong.

// File: rtl/reply_pacer.sv
module reply_pacer #(
  parameter int OP_W       = 8,
  parameter int MS_W       = 8,
  parameter int ENTRIES    = 8,
  parameter int DEFAULT_MS = 15,
  parameter int GAP_MS     = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_start,
  input  logic [OP_W-1:0]            req_opcode,
  input  logic                       tx_done,
  input  logic                       rx_byte,
  input  logic                       ms_tick,
  input  logic                       tbl_we,
  input  logic [$clog2(ENTRIES)-1:0] tbl_idx,
  input  logic                       tbl_valid,
  input  logic [OP_W-1:0]            tbl_opcode,
  input  logic [MS_W-1:0]            tbl_ms,
  output logic                       busy,
  output logic                       ok,
  output logic                       timeout,
  output logic                       launch,
  output logic [OP_W-1:0]            launch_op
);
  typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT, S_GAP} phase_t;

  phase_t            phase;
  logic [MS_W-1:0]   cnt, win;
  logic [OP_W-1:0]   cur_op, pend_op;
  logic              pend_v, ok_q, to_q;
  logic [ENTRIES-1:0] ent_v;
  logic [OP_W-1:0]   ent_op [ENTRIES];
  logic [MS_W-1:0]   ent_ms [ENTRIES];

  assign busy      = (phase != S_IDLE);
  assign launch    = (phase == S_IDLE) && pend_v;
  assign launch_op = pend_op;
  assign ok        = ok_q;
  assign timeout   = to_q;

  always_comb begin
    win = MS_W'(DEFAULT_MS);
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (ent_v[i] && ent_op[i] == cur_op) win = ent_ms[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ent_v <= '0;
    else if (tbl_we) ent_v[tbl_idx] <= tbl_valid;
  end

  always_ff @(posedge clk) begin
    if (tbl_we) begin
      ent_op[tbl_idx] <= tbl_opcode;
      ent_ms[tbl_idx] <= tbl_ms;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= S_IDLE;
      cnt     <= '0;
      cur_op  <= '0;
      pend_op <= '0;
      pend_v  <= 1'b0;
      ok_q    <= 1'b0;
      to_q    <= 1'b0;
    end else begin
      ok_q <= 1'b0;
      to_q <= 1'b0;
      case (phase)
        S_IDLE: if (pend_v) begin
          phase  <= S_SEND;
          cur_op <= pend_op;
        end
        S_SEND: if (tx_done) begin
          phase <= S_WAIT;
          cnt   <= win;
        end
        S_WAIT: begin
          if (rx_byte) begin
            ok_q  <= 1'b1;
            phase <= S_GAP;
            cnt   <= MS_W'(GAP_MS);
          end else if (ms_tick) begin
            if (cnt <= 1) begin
              to_q  <= 1'b1;
              phase <= S_GAP;
              cnt   <= MS_W'(GAP_MS);
            end else cnt <= cnt - 1'b1;
          end
        end
        default: if (ms_tick) begin
          if (cnt <= 1) phase <= S_IDLE;
          else cnt <= cnt - 1'b1;
        end
      endcase
      if (req_start) begin
        pend_v  <= 1'b1;
        pend_op <= req_opcode;
      end else if (launch) pend_v <= 1'b0;
    end
  end
endmodule

module reply_pacer_chk #(
  parameter int GAP_MS = 32
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic ok,
  input logic timeout,
  input logic launch,
  input logic ms_tick
);
  logic [15:0] since;
  logic        seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since <= '0;
      seen  <= 1'b0;
    end else if (ok || timeout) begin
      since <= {15'd0, ms_tick};
      seen  <= 1'b1;
    end else if (ms_tick && since != 16'hFFFF) begin
      since <= since + 1'b1;
    end
  end

  // R8
  ok_timeout_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(ok && timeout));
  // R8
  ok_single_chk: assert property (@(posedge clk) disable iff (!rst_n) ok |=> !ok);
  // R8
  timeout_single_chk: assert property (@(posedge clk) disable iff (!rst_n) timeout |=> !timeout);
  // R2
  launch_then_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) launch |=> busy);
  // R6
  result_in_exchange_chk: assert property (@(posedge clk) disable iff (!rst_n) (ok || timeout) |-> busy);
  // R10
  guard_gap_chk: assert property (@(posedge clk) disable iff (!rst_n) (launch && seen) |-> (since >= 16'(GAP_MS)));
endmodule

bind reply_pacer reply_pacer_chk #(.GAP_MS(GAP_MS)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .ok(ok), .timeout(timeout),
  .launch(launch), .ms_tick(ms_tick)
);

// File: tb/test_reply_pacer.sv
module test_reply_pacer;
  localparam int DEF = 15;
  localparam int GAP = 32;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, req_start, tx_done, rx_byte, tbl_we, tbl_valid;
  logic [7:0] req_opcode, tbl_opcode, tbl_ms, launch_op;
  logic [2:0] tbl_idx;
  logic busy, ok, timeout, launch, ms_tick;
  logic auto_tick, man_tick, div_tick;
  int div = 0;

  assign ms_tick = auto_tick ? div_tick : man_tick;

  reply_pacer i_reply_pacer (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_opcode(req_opcode),
    .tx_done(tx_done), .rx_byte(rx_byte), .ms_tick(ms_tick), .tbl_we(tbl_we),
    .tbl_idx(tbl_idx), .tbl_valid(tbl_valid), .tbl_opcode(tbl_opcode), .tbl_ms(tbl_ms),
    .busy(busy), .ok(ok), .timeout(timeout), .launch(launch), .launch_op(launch_op)
  );

  int checks = 0, errors = 0;
  int tick_cnt = 0, ok_seen = 0, to_seen = 0, cyc = 0;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    div <= div + 1;
    div_tick <= (div % 8 == 7);
  end

  // behavioural reference model
  int ph, mcnt, mpend, mpop, mcur, e_ok, e_to, lnch;
  int m_v[8], m_op[8], m_ms[8];

  function automatic int look(int op);
    for (int i = 0; i < 8; i++) if (m_v[i] != 0 && m_op[i] == op) return m_ms[i];
    return DEF;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      ph = 0; mcnt = 0; mpend = 0; mpop = 0; mcur = 0; e_ok = 0; e_to = 0;
      for (int i = 0; i < 8; i++) m_v[i] = 0;
    end else begin
      ok_seen += ok;
      to_seen += timeout;
      tick_cnt += ms_tick;
      lnch = (ph == 0 && mpend != 0);
      e_ok = 0; e_to = 0;
      case (ph)
        0: if (lnch != 0) begin ph = 1; mcur = mpop; end
        1: if (tx_done) begin ph = 2; mcnt = look(mcur); end
        2: if (rx_byte) begin e_ok = 1; ph = 3; mcnt = GAP; end
           else if (ms_tick) begin
             if (mcnt <= 1) begin e_to = 1; ph = 3; mcnt = GAP; end
             else mcnt--;
           end
        default: if (ms_tick) begin
          if (mcnt <= 1) ph = 0; else mcnt--;
        end
      endcase
      if (req_start) begin mpend = 1; mpop = req_opcode; end
      else if (lnch != 0) mpend = 0;
      if (tbl_we) begin
        m_v[tbl_idx] = tbl_valid; m_op[tbl_idx] = tbl_opcode; m_ms[tbl_idx] = tbl_ms;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2", "busy", busy, ph != 0);
      chk("R3", "launch", launch, ph == 0 && mpend != 0);
      if (ph == 0 && mpend != 0) chk("R3", "launch_op", launch_op, mpop);
      chk("R7", "ok", ok, e_ok);
      chk("R6", "timeout", timeout, e_to);
    end
  end

  always @(posedge clk) begin
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wr(int idx, int v, int op, int ms);
    @(negedge clk);
    tbl_we = 1; tbl_idx = 3'(idx); tbl_valid = v[0]; tbl_opcode = 8'(op); tbl_ms = 8'(ms);
    @(negedge clk);
    tbl_we = 0;
  endtask

  task automatic send_req(int op);
    @(negedge clk);
    req_start = 1; req_opcode = 8'(op);
    @(negedge clk);
    req_start = 0;
  endtask

  task automatic wait_launch(string tag, int op);
    int n = 0;
    while (!launch && n < 5000) begin @(negedge clk); n++; end
    chk(tag, "launch seen", launch, 1);
    chk(tag, "granted opcode", launch_op, op);
  endtask

  task automatic txd(output int t0);
    @(negedge clk); tx_done = 1;
    @(negedge clk); tx_done = 0;
    t0 = tick_cnt;
  endtask

  task automatic wait_result();
    int n = 0;
    while (!ok && !timeout && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic wait_idle();
    int n = 0;
    while ((busy || launch) && n < 5000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int t0, g0, o0, x0;
    rst_n = 0; req_start = 0; req_opcode = 0; tx_done = 0; rx_byte = 0;
    tbl_we = 0; tbl_idx = 0; tbl_valid = 0; tbl_opcode = 0; tbl_ms = 0;
    auto_tick = 1; man_tick = 0; div_tick = 0;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1", "busy", busy, 0);
    chk("R1", "ok", ok, 0);
    chk("R1", "timeout", timeout, 0);
    chk("R1", "launch", launch, 0);
    rst_n = 1;

    // R4 table contents: 0x11 twice (lower index wins), 0x33 with zero window
    wr(0, 1, 'h11, 60);
    wr(1, 1, 'h22, 40);
    wr(2, 1, 'h11, 5);
    wr(3, 1, 'h33, 0);
    wr(4, 0, 'h05, 3);

    // R5 default window, R6 timeout
    send_req('h05);
    wait_launch("R2", 'h05);
    txd(t0);
    wait_result();
    chk("R6", "timeout pulse", timeout, 1);
    chk("R5", "default window ticks", tick_cnt - t0, DEF);
    g0 = tick_cnt;
    // R3 request during gap is held; R10 gap length
    send_req('h11);
    wait_launch("R3", 'h11);
    chk("R10", "ticks from result to launch", tick_cnt - g0, GAP);

    // R4 R5 table match, lowest index wins
    txd(t0);
    wait_result();
    chk("R5", "table window ticks", tick_cnt - t0, 60);
    chk("R4", "timeout after table window", timeout, 1);
    wait_idle();

    // R7 reply with extra bytes, R8 one result
    o0 = ok_seen; x0 = to_seen;
    send_req('h22);
    wait_launch("R2", 'h22);
    txd(t0);
    while (tick_cnt - t0 < 3) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); rx_byte = 1;
      @(negedge clk); rx_byte = 0;
      if (k == 0) chk("R7", "ok after first byte", ok, 1);
    end
    // R3 replacement of pending opcode
    send_req('h05);
    send_req('h22);
    wait_launch("R3", 'h22);
    chk("R7", "ok count", ok_seen - o0, 1);
    chk("R8", "timeout count", to_seen - x0, 0);
    txd(t0);
    wait_result();
    chk("R5", "window 0x22", tick_cnt - t0, 40);
    wait_idle();

    // R9 stray strobes while idle
    o0 = ok_seen; x0 = to_seen;
    @(negedge clk); rx_byte = 1; tx_done = 1;
    @(negedge clk); rx_byte = 0; tx_done = 0;
    repeat (20) @(negedge clk);
    chk("R9", "busy after stray strobes", busy, 0);
    chk("R9", "no result from stray strobes", ok_seen + to_seen - o0 - x0, 0);

    // R9 rx during send ignored, R11 zero window
    send_req('h33);
    wait_launch("R2", 'h33);
    @(negedge clk); rx_byte = 1;
    @(negedge clk); rx_byte = 0;
    repeat (2) @(negedge clk);
    chk("R9", "no ok from byte during send", ok_seen - o0, 0);
    txd(t0);
    wait_result();
    chk("R11", "zero window acts as one tick", tick_cnt - t0, 1);
    chk("R11", "timeout pulse", timeout, 1);
    wait_idle();

    // R7 reply byte coincides with expiring tick
    auto_tick = 0;
    send_req('h33);
    wait_launch("R2", 'h33);
    txd(t0);
    @(negedge clk); man_tick = 1; rx_byte = 1;
    @(negedge clk); man_tick = 0; rx_byte = 0;
    chk("R7", "ok wins tie", ok, 1);
    chk("R8", "no timeout on tie", timeout, 0);
    auto_tick = 1;
    wait_idle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule